// File: doc/BRIEF.md
# Transducer Array Element Select Controller

This block is the digital control plane for a square grid of transmit/receive cells behind a two-dimensional ultrasound transducer array. Only one cell is active at a time. A row address and a column address pick that cell. A mode input decides whether the cell transmits or receives. While the cell transmits, a pulse input shapes the waveform it drives. Each cell gets four control lines: a pull-up gate and a pull-down gate for its three-state pulser, an enable that closes its protection switch, and an amplifier power enable. Each column also gets one enable for the output buffer that its cells share.

The addresses, the mode and the pulse input are captured on a clock edge. The per-cell outputs are then produced from registers, so every output changes on a single edge. The pull-up and pull-down gates of a cell are never on together. A driven-high pulse never meets a driven-low interval without at least one cycle of high impedance between them. This gap is added without shortening the high pulse.

Top module: `elem_sel_ctrl`

## Requirements
- R1: While `rst_i` is high at a rising edge, every output is low after that edge. The first capture of the inputs takes place at the first edge with `rst_i` low.
- R2: At most one cell has any of pull-up, pull-down or switch-close asserted. Only the addressed cell may have them. Cell index = row × 16 + column with the default parameters, and bit k of each per-cell vector belongs to cell k.
- R3: While the mode input is high, the addressed cell has its amplifier off and its switch open. Its pull-up gate copies the pulse input.
- R4: With address and mode held, a pulse input held high for N cycles gives exactly N cycles of pull-up on the addressed cell.
- R5: While the mode input is low, the addressed cell has its amplifier on and its switch closed, and both of its pulser gates are low.
- R6: No cell ever has pull-up and pull-down asserted in the same cycle.
- R7: Pull-down is low in the cycle just after a pull-up cycle and in the cycle just before one. It is asserted only while the mode is high, the pulse input is low, and neither neighbouring cycle is a pull-up cycle.
- R8: The buffer enable is set only for the addressed column, and only in receive mode. At most one buffer enable is set.
- R9: An input value captured at edge k appears on all outputs together after edge k+2.
- R10: Cells that are not addressed keep both gates low, the switch open and the amplifier off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| row_addr_i | input | ROW_W (4) | Row of the active cell |
| col_addr_i | input | COL_W (4) | Column of the active cell |
| tx_mode_i | input | 1 | 1 = transmit, 0 = receive |
| tx_pulse_i | input | 1 | Pulse shape; 1 = drive high while transmitting |
| pull_up_o | output | 2^(ROW_W+COL_W) | Per-cell pulser pull-up gate |
| pull_dn_o | output | 2^(ROW_W+COL_W) | Per-cell pulser pull-down gate |
| sw_close_o | output | 2^(ROW_W+COL_W) | Per-cell protection switch closed |
| amp_pwr_o | output | 2^(ROW_W+COL_W) | Per-cell preamplifier power |
| col_buf_o | output | 2^COL_W | Per-column output buffer enable |

## Verification
The bench builds the block with the default 4-bit row and column addresses, giving a full 16 × 16 grid of 256 cells. At this size the corner cells (0,0) and (15,15) and the middle of the grid can all be addressed directly. A random sweep also reaches many interior cells with address changes during transmit. One-cycle pulse toggles make the pull-down gap meet both edges of a pull-up pulse, and a reset asserted in the middle of a pulse is also covered.

// File: rtl/elem_sel_pkg.sv
package elem_sel_pkg;

  // Mode a cell is in at one pipeline stage.
  typedef enum logic [1:0] {
    CM_IDLE = 2'd0,
    CM_RX   = 2'd1,
    CM_TXH  = 2'd2,
    CM_TXL  = 2'd3
  } cell_mode_e;

  function automatic cell_mode_e cell_mode(input logic hit, input logic tx, input logic pulse);
    if (!hit)      return CM_IDLE;
    else if (!tx)  return CM_RX;
    else if (pulse) return CM_TXH;
    else           return CM_TXL;
  endfunction

endpackage

// File: rtl/elem_sel_capture.sv
module elem_sel_capture #(
  parameter int ROW_W = 4,
  parameter int COL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             tx_i,
  input  logic             pulse_i,
  output logic [ROW_W-1:0] row_q,
  output logic [COL_W-1:0] col_q,
  output logic             tx_q,
  output logic             pulse_q,
  output logic             armed_q
);

  // armed_q keeps every cell idle until a real sample has been taken.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      row_q   <= '0;
      col_q   <= '0;
      tx_q    <= 1'b0;
      pulse_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      row_q   <= row_i;
      col_q   <= col_i;
      tx_q    <= tx_i;
      pulse_q <= pulse_i;
      armed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/elem_sel_onehot.sv
module elem_sel_onehot #(
  parameter int W = 4,
  localparam int N = 1 << W
) (
  input  logic [W-1:0] code_i,
  input  logic         en_i,
  output logic [N-1:0] hot_o
);

  for (genvar k = 0; k < N; k++) begin : g_line
    assign hot_o[k] = en_i && (code_i == W'(k));
  end

endmodule

// File: rtl/elem_sel_cell.sv
module elem_sel_cell
  import elem_sel_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic hit_i,
  input  logic tx_i,
  input  logic pulse_i,
  output logic pull_up_o,
  output logic pull_dn_o,
  output logic sw_close_o,
  output logic amp_pwr_o,
  output logic rx_stage_o
);

  cell_mode_e now_m;  // mode from freshly captured inputs (look-ahead)
  cell_mode_e cur_m;  // mode being presented this cycle
  cell_mode_e old_m;  // mode presented one cycle before (look-back)

  assign now_m      = cell_mode(hit_i, tx_i, pulse_i);
  assign rx_stage_o = (cur_m == CM_RX);

  // Pull-up tracks cur_m exactly, so pulse width is preserved; pull-down
  // gives up the cycles adjacent to a high pulse on either side.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cur_m      <= CM_IDLE;
      old_m      <= CM_IDLE;
      pull_up_o  <= 1'b0;
      pull_dn_o  <= 1'b0;
      sw_close_o <= 1'b0;
      amp_pwr_o  <= 1'b0;
    end else begin
      cur_m      <= now_m;
      old_m      <= cur_m;
      pull_up_o  <= (cur_m == CM_TXH);
      pull_dn_o  <= (cur_m == CM_TXL) && (now_m != CM_TXH) && (old_m != CM_TXH);
      sw_close_o <= (cur_m == CM_RX);
      amp_pwr_o  <= (cur_m == CM_RX);
    end
  end

endmodule

// File: rtl/elem_sel_ctrl.sv
module elem_sel_ctrl #(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  localparam int NROWS  = 1 << ROW_W,
  localparam int NCOLS  = 1 << COL_W,
  localparam int NCELLS = NROWS * NCOLS
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ROW_W-1:0]  row_addr_i,
  input  logic [COL_W-1:0]  col_addr_i,
  input  logic              tx_mode_i,
  input  logic              tx_pulse_i,
  output logic [NCELLS-1:0] pull_up_o,
  output logic [NCELLS-1:0] pull_dn_o,
  output logic [NCELLS-1:0] sw_close_o,
  output logic [NCELLS-1:0] amp_pwr_o,
  output logic [NCOLS-1:0]  col_buf_o
);

  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              tx_q;
  logic              pulse_q;
  logic              armed_q;
  logic [NROWS-1:0]  row_hot;
  logic [NCOLS-1:0]  col_hot;
  logic [NCELLS-1:0] rx_stage;
  logic [NROWS-1:0]  col_rx [NCOLS];

  elem_sel_capture #(.ROW_W(ROW_W), .COL_W(COL_W)) u_cap (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .row_i   (row_addr_i),
    .col_i   (col_addr_i),
    .tx_i    (tx_mode_i),
    .pulse_i (tx_pulse_i),
    .row_q   (row_q),
    .col_q   (col_q),
    .tx_q    (tx_q),
    .pulse_q (pulse_q),
    .armed_q (armed_q)
  );

  elem_sel_onehot #(.W(ROW_W)) u_row_dec (
    .code_i (row_q),
    .en_i   (armed_q),
    .hot_o  (row_hot)
  );

  elem_sel_onehot #(.W(COL_W)) u_col_dec (
    .code_i (col_q),
    .en_i   (armed_q),
    .hot_o  (col_hot)
  );

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    for (genvar c = 0; c < NCOLS; c++) begin : g_col
      localparam int IDX = r * NCOLS + c;
      elem_sel_cell u_cell (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .hit_i      (row_hot[r] && col_hot[c]),
        .tx_i       (tx_q),
        .pulse_i    (pulse_q),
        .pull_up_o  (pull_up_o[IDX]),
        .pull_dn_o  (pull_dn_o[IDX]),
        .sw_close_o (sw_close_o[IDX]),
        .amp_pwr_o  (amp_pwr_o[IDX]),
        .rx_stage_o (rx_stage[IDX])
      );
      assign col_rx[c][r] = rx_stage[IDX];
    end
  end

  // Shared column buffer: powered only while a cell of its column receives.
  for (genvar c = 0; c < NCOLS; c++) begin : g_buf
    always_ff @(posedge clk_i) begin
      if (rst_i) col_buf_o[c] <= 1'b0;
      else       col_buf_o[c] <= |col_rx[c];
    end
  end

endmodule

// File: rtl/elem_sel_checker.sv
module elem_sel_checker #(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  localparam int NCOLS  = 1 << COL_W,
  localparam int NCELLS = (1 << ROW_W) * NCOLS
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [ROW_W-1:0]  row_addr_i,
  input logic [COL_W-1:0]  col_addr_i,
  input logic              tx_mode_i,
  input logic              tx_pulse_i,
  input logic [NCELLS-1:0] pull_up_o,
  input logic [NCELLS-1:0] pull_dn_o,
  input logic [NCELLS-1:0] sw_close_o,
  input logic [NCELLS-1:0] amp_pwr_o,
  input logic [NCOLS-1:0]  col_buf_o
);

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    rst_i |=> (pull_up_o == '0 && pull_dn_o == '0 && sw_close_o == '0 &&
               amp_pwr_o == '0 && col_buf_o == '0));

  assert_single_cell_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(pull_up_o | pull_dn_o | sw_close_o) <= 1);

  assert_tx_switch_open_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (|pull_up_o) |-> (sw_close_o == '0 && amp_pwr_o == '0));

  assert_no_shoot_through_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (pull_up_o & pull_dn_o) == '0);

  assert_gap_after_high_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (pull_dn_o & $past(pull_up_o)) == '0);

  assert_gap_before_high_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (pull_up_o & $past(pull_dn_o)) == '0);

  assert_one_buffer_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(col_buf_o));

  assert_buffer_in_rx_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (|col_buf_o) |-> (|amp_pwr_o));

endmodule

bind elem_sel_ctrl elem_sel_checker #(.ROW_W(ROW_W), .COL_W(COL_W)) chk_i (.*);

// File: tb/elem_sel_ctrl_tb_top.sv
module elem_sel_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W  = 4;
  localparam int COL_W  = 4;
  localparam int NCOLS  = 1 << COL_W;
  localparam int NCELLS = (1 << ROW_W) * NCOLS;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ROW_W-1:0]  row = '0;
  logic [COL_W-1:0]  col = '0;
  logic              txm = 1'b0;
  logic              pls = 1'b0;
  logic [NCELLS-1:0] pu, pd, sw, amp;
  logic [NCOLS-1:0]  bufe;

  int vecs = 0;
  int errs = 0;
  int pu_cnt = 0;
  bit started = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  elem_sel_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W)) dut_i (
    .clk_i(clk), .rst_i(rst), .row_addr_i(row), .col_addr_i(col),
    .tx_mode_i(txm), .tx_pulse_i(pls),
    .pull_up_o(pu), .pull_dn_o(pd), .sw_close_o(sw), .amp_pwr_o(amp),
    .col_buf_o(bufe)
  );

  // Behavioural reference: history of captured input snapshots.
  typedef struct { bit v; int r; int c; bit tx; bit p; } snap_t;
  snap_t s0, sa, sb, sc;
  localparam snap_t IDLE_SNAP = '{v:0, r:0, c:0, tx:0, p:0};

  // 0 idle, 1 receive, 2 drive high, 3 drive low
  function automatic int mode_at(snap_t s, int r, int c);
    if (!s.v || s.r != r || s.c != c) return 0;
    if (!s.tx) return 1;
    return s.p ? 2 : 3;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      s0 = IDLE_SNAP; sa = IDLE_SNAP; sb = IDLE_SNAP; sc = IDLE_SNAP;
    end else begin
      sc = sb; sb = sa; sa = s0;
      s0 = '{v:1, r:int'(row), c:int'(col), tx:txm, p:pls};
    end
  end

  task automatic fail_line(string req, string what, logic [NCELLS-1:0] act, logic [NCELLS-1:0] exp);
    errs++;
    $display("FAIL %s %s at %0t: actual %h expected %h", req, what, $time, act, exp);
  endtask

  always @(negedge clk) begin
    logic [NCELLS-1:0] e_pu, e_pd, e_sw;
    logic [NCOLS-1:0]  e_buf;
    int idx, m, ma, mc;
    string tag;
    if (started && !done) begin
      e_pu = '0; e_pd = '0; e_sw = '0; e_buf = '0;
      if (sb.v) begin
        idx = sb.r * NCOLS + sb.c;
        m  = mode_at(sb, sb.r, sb.c);
        ma = mode_at(sa, sb.r, sb.c);
        mc = mode_at(sc, sb.r, sb.c);
        e_pu[idx] = (m == 2);
        e_pd[idx] = (m == 3) && (ma != 2) && (mc != 2);
        e_sw[idx] = (m == 1);
        e_buf[sb.c] = (m == 1);
      end
      vecs++;
      if (rst) tag = "R1"; else tag = "R3/R10";
      if (pu !== e_pu) fail_line(tag, "pull_up", pu, e_pu);
      if (rst) tag = "R1"; else tag = "R7";
      if (pd !== e_pd) fail_line(tag, "pull_dn", pd, e_pd);
      if (rst) tag = "R1"; else tag = "R5";
      if (sw !== e_sw) fail_line(tag, "sw_close", sw, e_sw);
      if (amp !== e_sw) fail_line(tag, "amp_pwr", amp, e_sw);
      if (rst) tag = "R1"; else tag = "R8";
      if (bufe !== e_buf) fail_line(tag, "col_buf", NCELLS'(bufe), NCELLS'(e_buf));
      if ($countones(pu | pd | sw) > 1) fail_line("R2", "active cells", pu | pd | sw, e_pu | e_pd | e_sw);
      if ((pu & pd) != '0) fail_line("R6", "overlap", pu & pd, '0);
      if (|pu) pu_cnt++;
    end
  end

  task automatic drive(int r, int c, bit tx, bit p, int n);
    @(negedge clk);
    row = ROW_W'(r); col = COL_W'(c); txm = tx; pls = p;
    if (n > 1) repeat (n - 1) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp, string what);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  task automatic pulse_width(int r, int c, int w);
    drive(r, c, 1, 0, 4);
    pu_cnt = 0;
    drive(r, c, 1, 1, w);
    drive(r, c, 1, 0, 6);
    chk("R4", pu_cnt, w, "pull-up cycles for pulse");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", int'(|{pu, pd, sw, amp, bufe}), 0, "outputs in reset");
    rst = 1'b0;

    // R5 receive on corners and centre
    drive(0, 0, 0, 0, 6);
    chk("R5", int'(sw[0]), 1, "switch closed at cell 0");
    chk("R8", int'(bufe), 1, "buffer of column 0");
    drive(15, 15, 0, 0, 6);
    chk("R5", int'(amp[NCELLS-1]), 1, "amp on at last cell");
    drive(7, 9, 0, 0, 6);

    // R9 latency: new address shows after the third edge
    @(negedge clk); row = 4'd9; col = 4'd4;
    @(negedge clk); chk("R9", int'(sw[9*16+4]), 0, "after capture edge");
    @(negedge clk); chk("R9", int'(sw[9*16+4]), 0, "after second edge");
    @(negedge clk); chk("R9", int'(sw[9*16+4]), 1, "after third edge");

    // R4 pulse widths
    pulse_width(3, 7, 1);
    pulse_width(3, 7, 2);
    pulse_width(0, 15, 3);
    pulse_width(15, 0, 5);

    // R7 fast toggles
    for (int i = 0; i < 12; i++) drive(5, 5, 1, i[0], 1);
    for (int i = 0; i < 12; i++) drive(5, 5, 1, i[1], 1);
    // address change while driving high
    drive(2, 2, 1, 1, 3);
    drive(2, 3, 1, 1, 3);
    drive(2, 3, 0, 0, 4);

    // reset in the middle of a pulse
    drive(6, 1, 1, 1, 3);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", int'(|{pu, pd, sw, amp, bufe}), 0, "outputs after mid-pulse reset");
    rst = 1'b0;

    // random sweep
    for (int i = 0; i < 3000; i++)
      drive($urandom_range(15), $urandom_range(15), $urandom_range(3) != 0,
            $urandom_range(1), $urandom_range(1, 4));
    drive(0, 0, 0, 0, 6);
    finish_run();
  end

endmodule